// File: doc/BRIEF.md
# Branch Resolution and Target Unit

This block resolves one branch instruction per cycle. It takes a 32-bit instruction word, the address of that instruction, and the 32-bit condition vector. It holds the count register and the link register itself. It decodes the instruction and reports whether the word is a branch. It then decides whether the branch is taken and produces the next fetch address. The decision and the address are combinational, so a fetch stage can steer from them in the same cycle.

Four encodings are recognised:

- a direct jump with a 24-bit word offset;
- a conditional jump with a 14-bit word offset;
- a conditional jump through the link register;
- a conditional jump through the count register.

Conditional forms carry a 5-bit option field. It combines a test of one selected condition bit with an optional pre-decrement of the count register and a test of the new count against zero. Relative targets are measured from the address of the branch itself.

When the instruction strobe is high and the word is a branch, the register updates take effect on the clock edge:

- the count register is decremented if the option field asks for it;
- the return address is stored in the link register if the link bit is set.

Separate write ports let the rest of the core load either register.

Top module: `brt_unit`

## Requirements
- R1: When instr[31:26] is 18, the word is a branch and is always taken. The byte displacement is {instr[25:2],2'b00}, sign-extended from 26 bits. The target is that displacement itself when instr[1] is 1, else the instruction address plus the displacement.
- R2: When instr[31:26] is 16, the byte displacement is {instr[15:2],2'b00}, sign-extended from 16 bits. The target is that displacement when instr[1] is 1, else the instruction address plus the displacement.
- R3: When instr[31:26] is 19 and instr[10:1] is 16, the target is the link register with its two low bits cleared. When instr[10:1] is 528, the target is the count register, zero-extended to the address width, with its two low bits cleared. In both cases instr[1] has no effect on the target.
- R4: For forms 16 and 19, the option field is opt = instr[25:21] and the select field is sel = instr[20:16]. The selected condition bit is cond[31-sel], so sel=0 picks the most significant bit. If opt[4] is 1, the bit test passes. Otherwise the test passes only when the selected bit equals opt[3].
- R5: If opt[2] is 1, the count test passes and the count register is untouched. Otherwise the count test uses ctr-1, which wraps from 0 to all ones. The test passes when that new value is non-zero if opt[1] is 0, or zero if opt[1] is 1. On an accepted branch the count register becomes ctr-1.
- R6: opt[0] has no effect on the taken decision, the target or the register updates.
- R7: A branch is taken only when both the bit test and the count test pass. When it is not taken, the next address is the instruction address plus 4.
- R8: Any other opcode, or opcode 19 with any other minor value, gives is_branch=0, taken=0 and next address = instruction address + 4. It changes no register.
- R9: When instr[0] is 1 on an accepted branch, the link register receives the instruction address plus 4, whether or not the branch is taken. A jump through the link register with instr[0] set uses the old link value as its target.
- R10: With the instruction strobe low, neither register is changed by the presented word. The combinational outputs still reflect it.
- R11: After reset both registers read 0. A register write-port strobe overrides the branch update of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | Instruction strobe; enables the register updates |
| br_instr | input | 32 | Instruction word |
| br_pc | input | AW | Address of the instruction |
| cond_bits | input | 32 | Condition vector |
| ctr_wr | input | 1 | Count register write strobe |
| ctr_wdata | input | CW | Count register write value |
| lr_wr | input | 1 | Link register write strobe |
| lr_wdata | input | AW | Link register write value |
| is_branch | output | 1 | Word is one of the four branch forms |
| taken | output | 1 | Branch taken |
| next_pc | output | AW | Next fetch address |
| ctr_q | output | CW | Count register |
| lr_q | output | AW | Link register |

## Verification
The bench builds the block with a 32-bit address and a 16-bit count register. The narrower count makes the all-ones wrap after decrementing from zero visible at the ports. The count-through target is then narrower than the address, so the zero-extension branch of the target logic is exercised. Negative displacements, absolute targets, link-and-return through the old link value, and a write-port collision with a decrementing branch are all driven.

// File: rtl/brt_pkg.sv
package brt_pkg;

   localparam logic [5:0] OPC_JUMP  = 6'd18;
   localparam logic [5:0] OPC_CJUMP = 6'd16;
   localparam logic [5:0] OPC_XL    = 6'd19;
   localparam logic [9:0] XO_TO_LR  = 10'd16;
   localparam logic [9:0] XO_TO_CTR = 10'd528;

   // Option field value meaning "ignore bit, keep count": used for direct jumps.
   localparam logic [4:0] OPT_ALWAYS = 5'b10100;

   typedef enum logic [2:0] {
      FORM_NONE,
      FORM_JUMP,
      FORM_CJUMP,
      FORM_TO_LR,
      FORM_TO_CTR
   } br_form_e;

   typedef struct packed {
      br_form_e    form;
      logic [4:0]  opt;
      logic [4:0]  sel;
      logic        abs_addr;
      logic        link;
      logic [25:0] disp;   // byte displacement, sign-extended to 26 bits
   } br_fields_t;

endpackage

// File: rtl/brt_decode.sv
module brt_decode
   import brt_pkg::*;
(
   input  logic [31:0] instr,
   output br_fields_t  fld
);

   logic [5:0] opc;
   logic [9:0] xo;

   assign opc = instr[31:26];
   assign xo  = instr[10:1];

   always_comb begin
      fld          = '0;
      fld.form     = FORM_NONE;
      fld.opt      = OPT_ALWAYS;
      fld.sel      = instr[20:16];
      fld.link     = instr[0];
      fld.abs_addr = instr[1];
      unique case (opc)
         OPC_JUMP: begin
            fld.form = FORM_JUMP;
            fld.disp = {instr[25:2], 2'b00};
         end
         OPC_CJUMP: begin
            fld.form = FORM_CJUMP;
            fld.opt  = instr[25:21];
            fld.disp = {{10{instr[15]}}, instr[15:2], 2'b00};
         end
         OPC_XL: begin
            fld.opt      = instr[25:21];
            fld.abs_addr = 1'b0;
            if (xo == XO_TO_LR)       fld.form = FORM_TO_LR;
            else if (xo == XO_TO_CTR) fld.form = FORM_TO_CTR;
            else                      fld.form = FORM_NONE;
         end
         default: fld.form = FORM_NONE;
      endcase
      if (fld.form == FORM_NONE) begin
         fld.link = 1'b0;
         fld.opt  = OPT_ALWAYS;
      end
   end

endmodule

// File: rtl/brt_cond.sv
module brt_cond #(
   parameter int CW = 32
) (
   input  logic [4:0]    opt,
   input  logic [4:0]    sel,
   input  logic [31:0]   cond_bits,
   input  logic [CW-1:0] ctr,
   output logic          bit_ok,
   output logic          cnt_ok,
   output logic          do_dec,
   output logic [CW-1:0] ctr_dec
);

   logic       sel_bit;
   logic       dec_zero;
   logic [4:0] idx;

   // sel counts from the most significant condition bit
   assign idx      = 5'd31 - sel;
   assign sel_bit  = cond_bits[idx];
   assign bit_ok   = opt[4] | (sel_bit == opt[3]);

   assign ctr_dec  = ctr - CW'(1);
   assign dec_zero = (ctr_dec == '0);
   assign do_dec   = ~opt[2];
   assign cnt_ok   = opt[2] | (dec_zero == opt[1]);

endmodule

// File: rtl/brt_target.sv
module brt_target
   import brt_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 32
) (
   input  br_form_e      form,
   input  logic [25:0]   disp,
   input  logic          abs_addr,
   input  logic          taken,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] lr,
   input  logic [CW-1:0] ctr,
   output logic [AW-1:0] next_pc,
   output logic [AW-1:0] ret_addr
);

   localparam logic [AW-1:0] WORD_MASK = ~AW'(3);

   logic [AW-1:0] disp_ext;
   logic [AW-1:0] ctr_ext;
   logic [AW-1:0] imm_tgt;
   logic [AW-1:0] tgt;

   generate
      if (AW > 26) begin : g_disp_sx
         assign disp_ext = {{(AW-26){disp[25]}}, disp};
      end else begin : g_disp_eq
         assign disp_ext = disp;
      end
      if (CW >= AW) begin : g_ctr_trunc
         assign ctr_ext = ctr[AW-1:0];
      end else begin : g_ctr_zx
         assign ctr_ext = {{(AW-CW){1'b0}}, ctr};
      end
   endgenerate

   assign ret_addr = pc + AW'(4);
   assign imm_tgt  = abs_addr ? disp_ext : pc + disp_ext;

   always_comb begin
      unique case (form)
         FORM_JUMP, FORM_CJUMP: tgt = imm_tgt;
         FORM_TO_LR:            tgt = lr & WORD_MASK;
         FORM_TO_CTR:           tgt = ctr_ext & WORD_MASK;
         default:               tgt = ret_addr;
      endcase
   end

   assign next_pc = taken ? tgt : ret_addr;

endmodule

// File: rtl/brt_unit.sv
module brt_unit
   import brt_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          br_valid,
   input  logic [31:0]   br_instr,
   input  logic [AW-1:0] br_pc,
   input  logic [31:0]   cond_bits,
   input  logic          ctr_wr,
   input  logic [CW-1:0] ctr_wdata,
   input  logic          lr_wr,
   input  logic [AW-1:0] lr_wdata,
   output logic          is_branch,
   output logic          taken,
   output logic [AW-1:0] next_pc,
   output logic [CW-1:0] ctr_q,
   output logic [AW-1:0] lr_q
);

   generate
      if (AW < 26 || AW > 64) begin : g_bad_aw
         $error("brt_unit: AW must lie in 26..64");
      end
      if (CW < 2 || CW > 64) begin : g_bad_cw
         $error("brt_unit: CW must lie in 2..64");
      end
   endgenerate

   br_fields_t    fld;
   logic          bit_ok;
   logic          cnt_ok;
   logic          do_dec;
   logic [CW-1:0] ctr_dec;
   logic [AW-1:0] ret_addr;
   logic          accept;

   brt_decode u_dec (
      .instr (br_instr),
      .fld   (fld)
   );

   brt_cond #(.CW(CW)) u_cond (
      .opt       (fld.opt),
      .sel       (fld.sel),
      .cond_bits (cond_bits),
      .ctr       (ctr_q),
      .bit_ok    (bit_ok),
      .cnt_ok    (cnt_ok),
      .do_dec    (do_dec),
      .ctr_dec   (ctr_dec)
   );

   assign is_branch = (fld.form != FORM_NONE);
   assign taken     = is_branch & bit_ok & cnt_ok;
   assign accept    = br_valid & is_branch;

   brt_target #(.AW(AW), .CW(CW)) u_tgt (
      .form     (fld.form),
      .disp     (fld.disp),
      .abs_addr (fld.abs_addr),
      .taken    (taken),
      .pc       (br_pc),
      .lr       (lr_q),
      .ctr      (ctr_q),
      .next_pc  (next_pc),
      .ret_addr (ret_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctr_q <= '0;
         lr_q  <= '0;
      end else begin
         if (ctr_wr)                ctr_q <= ctr_wdata;
         else if (accept && do_dec) ctr_q <= ctr_dec;
         if (lr_wr)                 lr_q  <= lr_wdata;
         else if (accept && fld.link) lr_q <= ret_addr;
      end
   end

endmodule

// File: rtl/brt_unit_chk.sv
module brt_unit_chk #(
   parameter int AW = 32,
   parameter int CW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          br_valid,
   input logic [31:0]   br_instr,
   input logic [AW-1:0] br_pc,
   input logic          ctr_wr,
   input logic          lr_wr,
   input logic          is_branch,
   input logic          taken,
   input logic [AW-1:0] next_pc,
   input logic [CW-1:0] ctr_q,
   input logic [AW-1:0] lr_q
);

   AST_NONBR_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      !is_branch |-> (!taken && next_pc == br_pc + AW'(4))); // R8

   AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (is_branch && !taken) |-> (next_pc == br_pc + AW'(4))); // R7

   AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (br_instr[31:26] == 6'd18) |-> (is_branch && taken)); // R1

   AST_IDLE_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_valid && !ctr_wr) |=> $stable(ctr_q)); // R10

   AST_IDLE_LR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_valid && !lr_wr) |=> $stable(lr_q)); // R10

   AST_LINK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && is_branch && br_instr[0] && !lr_wr)
      |=> (lr_q == $past(br_pc) + AW'(4))); // R9

   AST_CTR_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && is_branch && br_instr[31:26] != 6'd18 && !br_instr[23] && !ctr_wr)
      |=> (ctr_q == $past(ctr_q) - CW'(1))); // R5

   AST_CTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && is_branch && br_instr[23] && !ctr_wr) |=> $stable(ctr_q)); // R5

endmodule

bind brt_unit brt_unit_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .br_valid  (br_valid),
   .br_instr  (br_instr),
   .br_pc     (br_pc),
   .ctr_wr    (ctr_wr),
   .lr_wr     (lr_wr),
   .is_branch (is_branch),
   .taken     (taken),
   .next_pc   (next_pc),
   .ctr_q     (ctr_q),
   .lr_q      (lr_q)
);

// File: tb/tb_brt_unit.sv
module tb_brt_unit;

   localparam int AW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          br_valid = 1'b0;
   logic [31:0]   br_instr = '0;
   logic [AW-1:0] br_pc = '0;
   logic [31:0]   cond_bits = '0;
   logic          ctr_wr = 1'b0;
   logic [CW-1:0] ctr_wdata = '0;
   logic          lr_wr = 1'b0;
   logic [AW-1:0] lr_wdata = '0;
   logic          is_branch;
   logic          taken;
   logic [AW-1:0] next_pc;
   logic [CW-1:0] ctr_q;
   logic [AW-1:0] lr_q;

   always #4 clk = ~clk;   // 125 MHz

   brt_unit #(.AW(AW), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_instr(br_instr),
      .br_pc(br_pc), .cond_bits(cond_bits), .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata),
      .lr_wr(lr_wr), .lr_wdata(lr_wdata), .is_branch(is_branch), .taken(taken),
      .next_pc(next_pc), .ctr_q(ctr_q), .lr_q(lr_q)
   );

   typedef struct {
      logic          isb;
      logic          tk;
      logic [AW-1:0] npc;
      logic [CW-1:0] ctr;
      logic [AW-1:0] lr;
      string         tag;
   } item_t;

   item_t         sb[$];
   int            n_chk = 0;
   int            n_fail = 0;
   logic [CW-1:0] m_ctr = '0;
   logic [AW-1:0] m_lr = '0;

   function automatic logic [31:0] mk_jump(input logic [23:0] off, input logic aa, input logic lk);
      return {6'd18, off, aa, lk};
   endfunction

   function automatic logic [31:0] mk_cjump(input logic [4:0] opt, input logic [4:0] sel,
                                            input logic [13:0] off, input logic aa, input logic lk);
      return {6'd16, opt, sel, off, aa, lk};
   endfunction

   function automatic logic [31:0] mk_xl(input logic [4:0] opt, input logic [4:0] sel,
                                         input logic [9:0] xo, input logic lk);
      return {6'd19, opt, sel, 5'd0, xo, lk};
   endfunction

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus, pushes the expected item, advances the model.
   task automatic step(input logic [31:0] ins, input logic [AW-1:0] pc, input logic [31:0] cr,
                       input logic vld, input logic cw, input logic [CW-1:0] cwd,
                       input logic lw, input logic [AW-1:0] lwd, input string tag);
      item_t                it;
      logic [5:0]           opc;
      logic [9:0]           xo;
      logic [4:0]           opt;
      logic [4:0]           sel;
      logic signed [25:0]   d26;
      logic signed [15:0]   d16;
      logic [AW-1:0]        tgt;
      logic [CW-1:0]        nc;
      logic                 isb, tk, dec, lk, pbit, pcnt;
      @(negedge clk);
      br_instr = ins; br_pc = pc; cond_bits = cr; br_valid = vld;
      ctr_wr = cw; ctr_wdata = cwd; lr_wr = lw; lr_wdata = lwd;
      opc = ins[31:26]; xo = ins[10:1]; opt = ins[25:21]; sel = ins[20:16];
      isb = (opc == 6'd18) || (opc == 6'd16) || (opc == 6'd19 && (xo == 10'd16 || xo == 10'd528));
      nc  = m_ctr - 1'b1;
      tgt = pc + 32'd4;
      dec = 1'b0;
      if (opc == 6'd18) begin
         d26 = {ins[25:2], 2'b00};
         tgt = ins[1] ? AW'(d26) : pc + AW'(d26);
         tk  = 1'b1;
      end else begin
         pbit = opt[4] || (cr[31 - sel] == opt[3]);
         pcnt = opt[2] || ((nc == 0) == opt[1]);
         tk   = isb && pbit && pcnt;
         dec  = isb && !opt[2];
         if (opc == 6'd16) begin
            d16 = {ins[15:2], 2'b00};
            tgt = ins[1] ? AW'(d16) : pc + AW'(d16);
         end else if (xo == 10'd16) begin
            tgt = {m_lr[AW-1:2], 2'b00};
         end else begin
            tgt = {{(AW-CW){1'b0}}, m_ctr[CW-1:2], 2'b00};
         end
      end
      lk = isb && ins[0];
      it.isb = isb;
      it.tk  = tk;
      it.npc = tk ? tgt : pc + 32'd4;
      it.ctr = m_ctr;
      it.lr  = m_lr;
      it.tag = tag;
      sb.push_back(it);
      if (cw) m_ctr = cwd;
      else if (vld && dec) m_ctr = nc;
      if (lw) m_lr = lwd;
      else if (vld && lk) m_lr = pc + 32'd4;
   endtask

   // Monitor: compares outputs 3 ns after each falling edge
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         #3;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            chk(it.tag, "is_branch", 64'(is_branch), 64'(it.isb));
            chk(it.tag, "taken",     64'(taken),     64'(it.tk));
            chk(it.tag, "next_pc",   64'(next_pc),   64'(it.npc));
            chk(it.tag, "ctr_q",     64'(ctr_q),     64'(it.ctr));
            chk(it.tag, "lr_q",      64'(lr_q),      64'(it.lr));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(32'h0, 32'h100, 32'h0, 1, 0, 0, 0, 0, "R11 reset");
      step(32'h0, 32'h104, 32'h0, 1, 1, 16'd3, 1, 32'h1234, "R8 opcode0");
      step(mk_jump(-24'sd4, 0, 0), 32'h2000, 0, 1, 0, 0, 0, 0, "R1 rel");
      step(mk_jump(24'h40, 1, 1), 32'h3000, 0, 1, 0, 0, 0, 0, "R1 abs R9");
      step(mk_cjump(5'b10000, 0, 14'd5, 0, 0), 32'h4000, 0, 1, 0, 0, 0, 0, "R5 nz");
      step(mk_cjump(5'b10010, 0, 14'd5, 0, 0), 32'h4000, 0, 1, 0, 0, 0, 0, "R7 R5 z-miss");
      step(mk_cjump(5'b10010, 0, 14'd5, 0, 0), 32'h4000, 0, 1, 0, 0, 0, 0, "R5 z-hit");
      step(mk_cjump(5'b10000, 0, 14'd5, 0, 0), 32'h4000, 0, 1, 0, 0, 0, 0, "R5 wrap");
      step(mk_cjump(5'b01100, 2, -14'sd8, 0, 0), 32'h5000, 32'h2000_0000, 1, 0, 0, 0, 0, "R4 set");
      step(mk_cjump(5'b01100, 2, -14'sd8, 0, 0), 32'h5000, 32'h0, 1, 0, 0, 0, 0, "R4 clr");
      step(mk_cjump(5'b00100, 2, -14'sd8, 0, 0), 32'h5000, 32'h0, 1, 0, 0, 0, 0, "R4 want0");
      step(mk_cjump(5'b01101, 2, -14'sd8, 0, 0), 32'h5000, 32'h2000_0000, 1, 0, 0, 0, 0, "R6 hint");
      step(mk_cjump(5'b00101, 2, -14'sd8, 0, 0), 32'h5000, 32'h2000_0000, 1, 0, 0, 0, 0, "R6 hint0");
      step(mk_cjump(5'b10100, 0, 14'h10, 1, 0), 32'h5000, 0, 1, 0, 0, 0, 0, "R2 abs");
      step(mk_xl(5'd20, 5'd31, 10'd16, 0), 32'h6000, 0, 1, 0, 0, 0, 0, "R3 to-lr");
      step(mk_xl(5'd20, 5'd31, 10'd16, 1), 32'h6004, 0, 1, 0, 0, 0, 0, "R9 old-lr");
      step(32'h0, 32'h6008, 0, 1, 1, 16'h1237, 0, 0, "R11 ctr load");
      step(mk_xl(5'd20, 5'd0, 10'd528, 0), 32'h7000, 0, 1, 0, 0, 0, 0, "R3 to-ctr");
      step(mk_xl(5'd16, 5'd0, 10'd0, 1), 32'h7004, 0, 1, 0, 0, 0, 0, "R8 xl-other");
      step({6'd31, 26'h0000215}, 32'h7008, 0, 1, 0, 0, 0, 0, "R8 op31");
      step(mk_cjump(5'b10000, 0, 14'd2, 0, 1), 32'h8000, 0, 0, 0, 0, 0, 0, "R10 idle");
      step(mk_cjump(5'b10000, 0, 14'd2, 0, 1), 32'h8000, 0, 1, 1, 16'h0050, 1, 32'hABC0, "R11 wr-wins");
      step(32'h0, 32'h9000, 0, 0, 0, 0, 0, 0, "R11 final");
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule